// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block builds the clock line timing for an I2C bus master. It takes the peripheral clock frequency in MHz, a target bus rate in kHz and a duty-ratio mode. From these it computes a 12-bit phase divider and a rise-time allowance. It then produces a repeating SCL pattern of low, release and high phases. Three ratios are available: standard mode with equal halves, fast mode with a 2:1 low-to-high split, and fast mode with a 16:9 split. Each ratio uses its own divider formula and its own minimum divider.

Software, or a sequencer above this block, loads a configuration while the generator is disabled. It then raises `enable` and pulses `start`. The block drives `scl_low` to pull the open-drain line down and watches `scl_in` to see the line level. The high phase count begins only once the line reads high, or once the rise-time allowance has run out. A target that holds the line low, or a slow rising edge, therefore cannot shorten the high time. A `stop` pulse or dropping `enable` releases the line.

Top module: `scl_timing_gen`

## Requirements
- R1: Standard mode (`cfg_mode`=2'b00, rate at most 100 kHz) sets divider = floor(freq_MHz*1000 / (2*rate_kHz)), clamped to at least 4. The low phase and the high phase each last divider cycles.
- R2: Fast 2:1 mode (`cfg_mode`=2'b01) sets divider = floor(freq_MHz*1000 / (3*rate_kHz)), clamped to at least 1. The low phase lasts 2*divider cycles and the high phase lasts divider cycles.
- R3: Fast 16:9 mode (`cfg_mode`=2'b10) sets divider = floor(freq_MHz*1000 / (25*rate_kHz)), clamped to at least 1. The low phase lasts 16*divider cycles and the high phase lasts 9*divider cycles.
- R4: The rise-time allowance is freq_MHz+1 in standard mode and floor(freq_MHz*300/1000)+1 in both fast modes.
- R5: `cfg_err` is 1 for any of these configurations: freq outside 2..36, rate of 0 or above 400, `cfg_mode`=2'b11, standard mode with rate above 100, a fast mode with rate of 100 or below, or a clamped divider above 4095. In that state `div_value` and `rise_allow` read 0 and `start` is ignored.
- R6: A `cfg_load` pulse updates `div_value`, `rise_allow` and `cfg_err` at the clock edge that samples it, and only if `enable` is low. A load while `enable` is high changes nothing.
- R7: A `start` pulse taken while enabled, error-free and idle makes `scl_low` 1 from the next edge, for the low-phase cycle count. The line is then released and a wait phase follows. The wait ends on the first cycle in which `scl_in` reads 1, or after rise-allowance cycles. The high phase then lasts its count, and the sequence repeats from the low phase.
- R8: `stop` or a low `enable` returns the generator to idle, with `scl_low` at 0 from the next edge. `stop` takes priority over `start`.
- R9: After reset, `scl_low`=0, `div_value`=0, `rise_allow`=0 and `cfg_err`=1, meaning unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator enable; locks the configuration while high |
| start | input | 1 | Pulse that begins SCL generation |
| stop | input | 1 | Pulse that halts generation and releases SCL |
| cfg_load | input | 1 | Strobe that captures the configuration inputs |
| cfg_freq_mhz | input | 6 | Peripheral clock frequency in MHz |
| cfg_speed_khz | input | 10 | Target bus rate in kHz |
| cfg_mode | input | 2 | 00 standard, 01 fast 2:1, 10 fast 16:9 |
| scl_in | input | 1 | Observed SCL line level |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| div_value | output | 12 | Computed phase divider |
| rise_allow | output | 7 | Computed rise-time allowance in cycles |
| cfg_err | output | 1 | Configuration invalid or not loaded |

## Verification
The computed divider, allowance and error flag are due at the same edge that samples `cfg_load`. Every change of `scl_low` is due exactly one edge after the input or counter state that causes it. The bench drives inputs and reads outputs one nanosecond after each rising edge. It advances a behavioural model with the inputs held across that edge and compares all four outputs in that same slot. Phase widths are also measured by counting samples of `scl_low`, both with the line following the driver and with the line held low so the rise allowance governs the release.

// File: rtl/scl_timing_pkg.sv
// Shared types for the SCL timing generator.
package scl_timing_pkg;

    // Duty-ratio selection; encodings are visible on cfg_mode.
    typedef enum logic [1:0] {
        M_STD     = 2'b00,
        M_FAST2   = 2'b01,
        M_FAST169 = 2'b10,
        M_BAD     = 2'b11
    } scl_mode_e;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_WAIT = 2'b10,
        PH_HIGH = 2'b11
    } scl_phase_e;

endpackage

// File: rtl/scl_cfg_unit.sv
// Configuration unit: validates the requested timing, computes the divider,
// rise allowance and per-phase cycle counts, and registers them on a load
// strobe taken while the generator is disabled.
// Assumes cfg_load is a single-cycle strobe; the arithmetic is evaluated in
// one cycle from the raw inputs.
module scl_cfg_unit
    import scl_timing_pkg::*;
#(
    parameter int FREQ_W       = 6,
    parameter int SPEED_W      = 10,
    parameter int DIV_W        = 12,
    parameter int FREQ_MIN     = 2,
    parameter int FREQ_MAX     = 36,
    parameter int STD_MAX_KHZ  = 100,
    parameter int FAST_MAX_KHZ = 400,
    parameter int STD_DIV_MIN  = 4,
    parameter int FAST_DIV_MIN = 1,
    localparam int RISE_W      = FREQ_W + 1,
    localparam int PHASE_W     = DIV_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_load,
    input  logic [FREQ_W-1:0]  cfg_freq_mhz,
    input  logic [SPEED_W-1:0] cfg_speed_khz,
    input  logic [1:0]         cfg_mode,
    output logic [DIV_W-1:0]   div_q,
    output logic [RISE_W-1:0]  rise_q,
    output logic [PHASE_W-1:0] low_q,
    output logic [PHASE_W-1:0] high_q,
    output logic               err_q
);

    localparam int DIV_MAX = (1 << DIV_W) - 1;

    scl_mode_e   mode_in;
    scl_mode_e   mode_q;
    logic [31:0] num, den, quo, clamped, rise_c, low_c, high_c;
    logic        err_c;

    assign mode_in = scl_mode_e'(cfg_mode);

    // Purpose: compute divider, allowance, phase counts and validity.
    always_comb begin
        num = 32'(cfg_freq_mhz) * 32'd1000;
        case (mode_in)
            M_STD:     den = 32'(cfg_speed_khz) * 32'd2;
            M_FAST2:   den = 32'(cfg_speed_khz) * 32'd3;
            default:   den = 32'(cfg_speed_khz) * 32'd25;
        endcase
        if (den == 32'd0) den = 32'd1;
        quo = num / den;
        if (mode_in == M_STD)
            clamped = (quo < 32'(STD_DIV_MIN)) ? 32'(STD_DIV_MIN) : quo;
        else
            clamped = (quo < 32'(FAST_DIV_MIN)) ? 32'(FAST_DIV_MIN) : quo;

        if (mode_in == M_STD)
            rise_c = 32'(cfg_freq_mhz) + 32'd1;
        else
            rise_c = (32'(cfg_freq_mhz) * 32'd300) / 32'd1000 + 32'd1;

        case (mode_in)
            M_FAST2:   begin low_c = clamped * 32'd2;  high_c = clamped; end
            M_FAST169: begin low_c = clamped * 32'd16; high_c = clamped * 32'd9; end
            default:   begin low_c = clamped;          high_c = clamped; end
        endcase

        err_c = (32'(cfg_freq_mhz) < 32'(FREQ_MIN))
             || (32'(cfg_freq_mhz) > 32'(FREQ_MAX))
             || (cfg_speed_khz == '0)
             || (32'(cfg_speed_khz) > 32'(FAST_MAX_KHZ))
             || (mode_in == M_BAD)
             || ((mode_in == M_STD) && (32'(cfg_speed_khz) > 32'(STD_MAX_KHZ)))
             || ((mode_in != M_STD) && (32'(cfg_speed_khz) <= 32'(STD_MAX_KHZ)))
             || (clamped > 32'(DIV_MAX));
    end

    // Purpose: capture the computed configuration only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            rise_q <= '0;
            low_q  <= '0;
            high_q <= '0;
            err_q  <= 1'b1;
            mode_q <= M_STD;
        end else if (cfg_load && !enable) begin
            err_q  <= err_c;
            mode_q <= mode_in;
            div_q  <= err_c ? '0 : DIV_W'(clamped);
            rise_q <= err_c ? '0 : RISE_W'(rise_c);
            low_q  <= err_c ? '0 : PHASE_W'(low_c);
            high_q <= err_c ? '0 : PHASE_W'(high_c);
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(div_q) && $stable(err_q) && $stable(rise_q))); // R6
    AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (div_q == '0 && rise_q == '0)); // R5
    AST_STD_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && mode_q == M_STD) |-> (32'(div_q) >= 32'(STD_DIV_MIN))); // R1
    AST_FAST169_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && mode_q == M_FAST169) |-> (32'(low_q) * 9 == 32'(high_q) * 16)); // R3

endmodule

// File: rtl/scl_phase_seq.sv
// Phase sequencer: walks low, wait and high phases using the registered
// phase counts. The wait phase ends on an observed high line or when the
// rise allowance runs out, so the high count starts from a real edge.
// Assumes scl_in is already synchronous to clk and phase counts are nonzero
// whenever the configuration is error-free.
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int RISE_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               start,
    input  logic               stop,
    input  logic               cfg_err,
    input  logic               scl_in,
    input  logic [PHASE_W-1:0] low_len,
    input  logic [PHASE_W-1:0] high_len,
    input  logic [RISE_W-1:0]  rise_len,
    output logic               scl_low
);

    scl_phase_e         state, state_n;
    logic [PHASE_W-1:0] cnt, cnt_n;
    logic               rise_done;

    assign rise_done = ({1'b0, cnt} + 1'b1) >= (PHASE_W+1)'(rise_len);

    // Purpose: choose the next phase and counter value.
    always_comb begin
        state_n = state;
        cnt_n   = cnt + 1'b1;
        if (!enable || stop) begin
            state_n = PH_IDLE;
            cnt_n   = '0;
        end else begin
            case (state)
                PH_IDLE: begin
                    cnt_n = '0;
                    if (start && !cfg_err) state_n = PH_LOW;
                end
                PH_LOW: if (cnt == low_len - 1'b1) begin
                    state_n = PH_WAIT;
                    cnt_n   = '0;
                end
                PH_WAIT: if (scl_in || rise_done) begin
                    state_n = PH_HIGH;
                    cnt_n   = '0;
                end
                PH_HIGH: if (cnt == high_len - 1'b1) begin
                    state_n = PH_LOW;
                    cnt_n   = '0;
                end
                default: begin
                    state_n = PH_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // Purpose: hold phase state and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assign scl_low = (state == PH_LOW);

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop || !enable) |=> !scl_low); // R8
    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && cfg_err) |=> (state == PH_IDLE)); // R5
    AST_HIGH_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH && $past(state) != PH_HIGH) |-> ($past(state) == PH_WAIT)); // R7
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOW) |-> (cnt < low_len)); // R7

endmodule

// File: rtl/scl_timing_gen.sv
// Top of the SCL timing generator: configuration unit plus phase sequencer.
// Assumes the surrounding master only loads configuration while disabled and
// drives the open-drain pad from scl_low.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int FREQ_W   = 6,
    parameter int SPEED_W  = 10,
    parameter int DIV_W    = 12,
    localparam int RISE_W  = FREQ_W + 1,
    localparam int PHASE_W = DIV_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               start,
    input  logic               stop,
    input  logic               cfg_load,
    input  logic [FREQ_W-1:0]  cfg_freq_mhz,
    input  logic [SPEED_W-1:0] cfg_speed_khz,
    input  logic [1:0]         cfg_mode,
    input  logic               scl_in,
    output logic               scl_low,
    output logic [DIV_W-1:0]   div_value,
    output logic [RISE_W-1:0]  rise_allow,
    output logic               cfg_err
);

    logic [PHASE_W-1:0] low_len, high_len;

    scl_cfg_unit #(
        .FREQ_W  (FREQ_W),
        .SPEED_W (SPEED_W),
        .DIV_W   (DIV_W)
    ) cfg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .cfg_load      (cfg_load),
        .cfg_freq_mhz  (cfg_freq_mhz),
        .cfg_speed_khz (cfg_speed_khz),
        .cfg_mode      (cfg_mode),
        .div_q         (div_value),
        .rise_q        (rise_allow),
        .low_q         (low_len),
        .high_q        (high_len),
        .err_q         (cfg_err)
    );

    scl_phase_seq #(
        .PHASE_W (PHASE_W),
        .RISE_W  (RISE_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start    (start),
        .stop     (stop),
        .cfg_err  (cfg_err),
        .scl_in   (scl_in),
        .low_len  (low_len),
        .high_len (high_len),
        .rise_len (rise_allow),
        .scl_low  (scl_low)
    );

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, start = 1'b0, stop = 1'b0, cfg_load = 1'b0;
    logic [5:0] cfg_freq_mhz = '0;
    logic [9:0] cfg_speed_khz = '0;
    logic [1:0] cfg_mode = '0;
    logic       hold_low = 1'b0;
    logic       scl_in, scl_low, cfg_err;
    logic [11:0] div_value;
    logic [6:0]  rise_allow;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_phase, m_cnt, m_div, m_rise, m_low, m_high;
    bit m_err;

    always #5 clk = ~clk;

    // Line follows the driver unless the bench stretches it low.
    assign scl_in = !scl_low && !hold_low;

    scl_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .stop(stop),
        .cfg_load(cfg_load), .cfg_freq_mhz(cfg_freq_mhz),
        .cfg_speed_khz(cfg_speed_khz), .cfg_mode(cfg_mode), .scl_in(scl_in),
        .scl_low(scl_low), .div_value(div_value), .rise_allow(rise_allow),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected configuration per R1..R5
    task automatic model_cfg(input int f, input int s, input int md);
        int q, c, d;
        bit e;
        d = (md == 0) ? 2 * s : (md == 1) ? 3 * s : 25 * s;
        if (d == 0) d = 1;
        q = (f * 1000) / d;
        c = (md == 0) ? ((q < 4) ? 4 : q) : ((q < 1) ? 1 : q);
        e = (f < 2) || (f > 36) || (s == 0) || (s > 400) || (md == 3)
            || (md == 0 && s > 100) || (md != 0 && s <= 100) || (c > 4095);
        m_err = e;
        if (e) begin
            m_div = 0; m_rise = 0; m_low = 0; m_high = 0;
        end else begin
            m_div  = c;
            m_rise = (md == 0) ? f + 1 : (f * 300) / 1000 + 1;
            m_low  = (md == 0) ? c : (md == 1) ? 2 * c : 16 * c;
            m_high = (md == 2) ? 9 * c : c;
        end
    endtask

    // One clock: capture held inputs, advance model, compare every output.
    task automatic tick();
        bit r, en, st, sp, ld, line;
        int f, s, md;
        r = rst_n; en = enable; st = start; sp = stop; ld = cfg_load;
        line = scl_in; f = cfg_freq_mhz; s = cfg_speed_khz; md = cfg_mode;
        @(posedge clk);
        #1;
        if (!r) begin
            m_phase = 0; m_cnt = 0; m_div = 0; m_rise = 0;
            m_low = 0; m_high = 0; m_err = 1;
        end else begin
            if (!en || sp) begin
                m_phase = 0; m_cnt = 0;
            end else if (m_phase == 0) begin
                m_cnt = 0;
                if (st && !m_err) m_phase = 1;
            end else if (m_phase == 1) begin
                if (m_cnt == m_low - 1) begin m_phase = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (m_phase == 2) begin
                if (line || m_cnt + 1 >= m_rise) begin m_phase = 3; m_cnt = 0; end
                else m_cnt++;
            end else begin
                if (m_cnt == m_high - 1) begin m_phase = 1; m_cnt = 0; end
                else m_cnt++;
            end
            if (ld && !en) model_cfg(f, s, md);
        end
        check("R7", "scl_low per cycle", int'(scl_low), (m_phase == 1) ? 1 : 0);
        check("R6", "div_value per cycle", int'(div_value), m_div);
        check("R6", "rise_allow per cycle", int'(rise_allow), m_rise);
        check("R6", "cfg_err per cycle", int'(cfg_err), int'(m_err));
    endtask

    task automatic configure(input int f, input int s, input int md);
        enable = 1'b0;
        cfg_freq_mhz = 6'(f); cfg_speed_khz = 10'(s); cfg_mode = 2'(md);
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic begin_run();
        enable = 1'b1; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic halt();
        stop = 1'b1;
        tick();
        stop = 1'b0; enable = 1'b0;
        tick();
    endtask

    // Counts consecutive cycles with scl_low at the given level.
    task automatic measure(input bit lvl, output int n);
        n = 0;
        while (scl_low == lvl && n < 2000) begin
            n++;
            tick();
        end
    endtask

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        check("R9", "reset scl_low", int'(scl_low), 0);
        check("R9", "reset div", int'(div_value), 0);
        check("R9", "reset rise", int'(rise_allow), 0);
        check("R9", "reset err", int'(cfg_err), 1);

        // R5: start ignored while unconfigured
        begin_run();
        repeat (3) tick();
        check("R5", "start blocked by err", int'(scl_low), 0);
        enable = 1'b0; tick();

        // R1 standard: 8 MHz, 100 kHz -> div 40, rise 9 (R4)
        configure(8, 100, 0);
        check("R1", "std divider", int'(div_value), 40);
        check("R4", "std rise", int'(rise_allow), 9);
        begin_run();
        measure(1'b1, n);
        check("R1", "std low width", n, 40);
        measure(1'b0, n);
        check("R1", "std release+high width", n, 41);
        repeat (150) tick();
        halt();

        // R2 fast 2:1: 36 MHz, 400 kHz -> div 30, rise 11
        configure(36, 400, 1);
        check("R2", "fast2 divider", int'(div_value), 30);
        check("R4", "fast rise", int'(rise_allow), 11);
        begin_run();
        measure(1'b1, n);
        check("R2", "fast2 low width", n, 60);
        measure(1'b0, n);
        check("R2", "fast2 release+high width", n, 31);
        // R7: line held low, wait lasts the rise allowance
        hold_low = 1'b1;
        measure(1'b1, n);
        measure(1'b0, n);
        check("R7", "stretched release+high width", n, 41);
        hold_low = 1'b0;
        repeat (100) tick();

        // R6: load while enabled changes nothing
        cfg_freq_mhz = 6'd8; cfg_speed_khz = 10'd100; cfg_mode = 2'd0;
        cfg_load = 1'b1; tick(); cfg_load = 1'b0; tick();
        check("R6", "locked divider", int'(div_value), 30);

        // R8: stop mid-low releases on next edge
        while (!scl_low) tick();
        repeat (5) tick();
        stop = 1'b1; start = 1'b1; tick();
        check("R8", "stop over start", int'(scl_low), 0);
        stop = 1'b0; start = 1'b0;
        repeat (4) tick();
        check("R8", "stays idle", int'(scl_low), 0);
        begin_run();
        repeat (10) tick();
        enable = 1'b0; tick();
        check("R8", "enable low releases", int'(scl_low), 0);

        // R3 fast 16:9: 36 MHz, 400 kHz -> div 3
        configure(36, 400, 2);
        check("R3", "f169 divider", int'(div_value), 3);
        begin_run();
        measure(1'b1, n);
        check("R3", "f169 low width", n, 48);
        measure(1'b0, n);
        check("R3", "f169 release+high width", n, 28);
        halt();
        // R3 clamp: 2 MHz, 400 kHz -> quotient 0 -> 1, rise 1
        configure(2, 400, 2);
        check("R3", "f169 clamp", int'(div_value), 1);
        check("R4", "fast rise low freq", int'(rise_allow), 1);
        begin_run();
        repeat (80) tick();
        halt();

        // R5 error cases
        configure(36, 1, 0);   check("R5", "overflow err", int'(cfg_err), 1);
        configure(8, 200, 0);  check("R5", "std too fast", int'(cfg_err), 1);
        configure(8, 50, 1);   check("R5", "fast too slow", int'(cfg_err), 1);
        configure(40, 400, 1); check("R5", "freq high", int'(cfg_err), 1);
        configure(1, 100, 0);  check("R5", "freq low", int'(cfg_err), 1);
        configure(36, 401, 2); check("R5", "rate high", int'(cfg_err), 1);
        configure(36, 400, 3); check("R5", "bad mode", int'(cfg_err), 1);
        check("R5", "err zeroes divider", int'(div_value), 0);
        configure(20, 0, 0);   check("R5", "zero rate", int'(cfg_err), 1);
        begin_run();
        repeat (3) tick();
        check("R5", "start blocked", int'(scl_low), 0);
        enable = 1'b0; tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule